// File: doc/BRIEF.md
# Descriptor-Ring Transmit DMA Channel

This block moves data from memory into the transmit FIFO of a USB IN endpoint. Software describes each outgoing buffer in a small ring of four-word descriptors. The channel reads the descriptor at the current ring index. It then streams the buffer one byte at a time into the FIFO, whenever the FIFO reports free space. When the byte count runs out, it writes the descriptor back with its ownership flag cleared and moves to the next ring slot. A buffer-complete interrupt can be enabled. Packet framing on the bus is handled elsewhere.

Descriptor n sits at ring base + 8n. Its four 16-bit words are:

| Offset | Content |
|---|---|
| +0 | Low 16 bits of the buffer address |
| +2 | Configuration: bit 15 marks hardware ownership, bits [3:0] are the upper address bits |
| +4 | Byte count: bit 15 set, bits [14:0] holding the two's-complement negative of the length |
| +6 | Not used by transmit |

The endpoint can report an underrun or a NAK at any time while the channel runs. Either report stops the channel at once. The live transmit address stays frozen, so software can compute how far transmission got, back the descriptor up to a packet boundary and restart. To restart, software writes the ring index and sets the start bit.

Registers (3-bit address, 16-bit data, written when `regWe` is high, read combinationally):

| Address | Register | Bits |
|---|---|---|
| 0 | Control | bit 0 start/running, bit 1 buffer-complete interrupt enable |
| 1 | Status, write 1 to clear | bit 0 buffer complete, bit 1 underrun, bit 2 NAK |
| 2 | Ring base, low | bits [15:4]; bits [3:0] read as zero |
| 3 | Ring base, high | bits [3:0] |
| 4 | Current ring index | |
| 5 | Live transmit address, low | read only |
| 6 | Live transmit address, high | read only |
| 7 | Bytes sent from the current buffer | read only |

Top module: `ring_tx_dma`

## Requirements
- R1: After reset, the control register reads 0, the status register reads 0, the ring index reads 0, `irq` is low, and neither `memReq` nor `fifoPush` is asserted.
- R2: A descriptor whose configuration bit 15 is clear is not transferred. The channel stops without setting any status bit, pushes no byte, writes nothing to memory, and leaves the ring index pointing at that descriptor.
- R3: An owned descriptor sends exactly len bytes, where len = (-count[14:0]) mod 2^15; a count word of 16'h8000 sends none. The bytes come in address order from the buffer start: an even byte address takes bits [7:0] of the memory word and an odd one takes bits [15:8]. After completion, register 7 reads len and the transmit address reads start + len.
- R4: `fifoPush` is asserted only in cycles in which `fifoSpace` is high.
- R5: When the last byte has been sent, the channel writes the configuration word back to its own slot (ring base + 8n + 2) with bit 15 cleared and bits [14:0] unchanged, exactly once, then advances the ring index by one.
- R6: The ring has 16 slots, and the index wraps from 15 to 0. The ring base is 16-byte aligned: bits [3:0] of the low base register always read 0.
- R7: When interrupt enable (control bit 1) is set, completing a buffer sets status bit 0 and drives `irq` high. When it is clear, neither happens. Writing 1 to a status bit clears it.
- R8: An `epUnderrun` pulse while running stops the channel and sets status bit 1. No further byte is pushed, the descriptor is not written back, and the transmit address and sent count stay equal to the buffer start plus the bytes already pushed.
- R9: An `epNak` pulse while running stops the channel the same way and sets status bit 2.
- R10: After an error stop, writing the ring index and then control bit 0 = 1 restarts from a fresh read of that descriptor. This allows a descriptor rewritten by software to resend from an earlier address.
- R11: If an error report arrives in the same cycle as the push of a buffer's last byte, the push still counts, but the stop wins: no write-back, no buffer-complete status, and the index does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data (combinational) |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Memory access is a write |
| memAddr | output | ADDR_W (20) | Memory byte address |
| memWdata | output | 16 | Memory write data |
| memAck | input | 1 | Memory accepted the access; read data valid |
| memRdata | input | 16 | Memory read data |
| fifoPush | output | 1 | Push one byte into the endpoint FIFO |
| fifoData | output | 8 | Byte being pushed |
| fifoSpace | input | 1 | FIFO can take a byte this cycle |
| epUnderrun | input | 1 | Endpoint reports an underrun |
| epNak | input | 1 | Endpoint reports a NAK on the last packet |
| irq | output | 1 | Buffer-complete interrupt |

## Verification
The key collision is a stop request from the endpoint landing in the very cycle that pushes a buffer's final byte. In that cycle, byte delivery and descriptor completion both want to act. The bench provokes it by watching the FIFO push and the push count at each falling edge. When the last byte is being pushed, it raises the underrun input for exactly that cycle. It then judges the outcome through the ports. The push count must include the final byte and register 7 must read the full length. There must be no configuration write-back, the buffer-complete bit must stay clear, and the ring index must be unchanged.

// File: rtl/ring_tx_dma_pkg.sv
package ring_tx_dma_pkg;

  // which descriptor word or data address the datapath drives onto memAddr
  typedef enum logic [1:0] {
    SEL_CFG  = 2'd0,
    SEL_ALO  = 2'd1,
    SEL_CNT  = 2'd2,
    SEL_DATA = 2'd3
  } addrSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic ldCfg;     // latch configuration word (owned descriptor)
    logic ldAddrLo;  // latch buffer start address
    logic ldLen;     // latch length from count word, zero sent count
    logic ldByte;    // latch the byte addressed by txAddr
    logic advByte;   // byte pushed: advance address and sent count
    logic bufDone;   // write-back accepted: advance index, flag completion
    logic ownIdle;   // descriptor not owned: stop quietly
    logic halt;      // endpoint error: stop and record cause
  } txStrobe_t;

  localparam logic [2:0] REG_CTRL   = 3'd0;
  localparam logic [2:0] REG_STAT   = 3'd1;
  localparam logic [2:0] REG_RINGLO = 3'd2;
  localparam logic [2:0] REG_RINGHI = 3'd3;
  localparam logic [2:0] REG_INDEX  = 3'd4;
  localparam logic [2:0] REG_TXLO   = 3'd5;
  localparam logic [2:0] REG_TXHI   = 3'd6;
  localparam logic [2:0] REG_SENT   = 3'd7;

endpackage

// File: rtl/ring_tx_dma_ctrl.sv
module ring_tx_dma_ctrl
  import ring_tx_dma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       run,
  input  logic       errIn,
  input  logic       lenDone,
  input  logic       ownBit,
  input  logic       memAck,
  input  logic       fifoSpace,
  output logic       memReq,
  output logic       memWe,
  output addrSel_t   addrSel,
  output logic       fifoPush,
  output txStrobe_t  stb
);

  typedef enum logic [2:0] {
    S_IDLE, S_CFG, S_ALO, S_CNT, S_CHK, S_FETCH, S_PUSH, S_WB
  } state_t;

  state_t st, stNext;
  logic   stopNow;

  assign stopNow = run && errIn;

  // memory request side, independent of the acknowledge
  always_comb begin
    memReq  = 1'b0;
    memWe   = 1'b0;
    addrSel = SEL_CFG;
    unique case (st)
      S_CFG:   begin memReq = 1'b1; addrSel = SEL_CFG;  end
      S_ALO:   begin memReq = 1'b1; addrSel = SEL_ALO;  end
      S_CNT:   begin memReq = 1'b1; addrSel = SEL_CNT;  end
      S_FETCH: begin memReq = 1'b1; addrSel = SEL_DATA; end
      S_WB:    begin memReq = 1'b1; memWe = 1'b1; addrSel = SEL_CFG; end
      default: ;
    endcase
    if (stopNow) begin
      memReq = 1'b0;
      memWe  = 1'b0;
    end
  end

  always_comb begin
    stb      = '0;
    fifoPush = 1'b0;
    stNext   = st;
    unique case (st)
      S_IDLE:  if (run) stNext = S_CFG;
      S_CFG:   if (memAck) begin
                 if (ownBit) begin stb.ldCfg = 1'b1; stNext = S_ALO; end
                 else begin stb.ownIdle = 1'b1; stNext = S_IDLE; end
               end
      S_ALO:   if (memAck) begin stb.ldAddrLo = 1'b1; stNext = S_CNT; end
      S_CNT:   if (memAck) begin stb.ldLen = 1'b1; stNext = S_CHK; end
      S_CHK:   stNext = lenDone ? S_WB : S_FETCH;
      S_FETCH: if (memAck) begin stb.ldByte = 1'b1; stNext = S_PUSH; end
      S_PUSH:  if (fifoSpace) begin
                 fifoPush    = 1'b1;
                 stb.advByte = 1'b1;
                 stNext      = S_CHK;
               end
      S_WB:    if (memAck) begin stb.bufDone = 1'b1; stNext = S_CFG; end
      default: stNext = S_IDLE;
    endcase
    // a stop request overrides all but a push already on the FIFO port
    if (stopNow) begin
      stb.ldCfg    = 1'b0;
      stb.ldAddrLo = 1'b0;
      stb.ldLen    = 1'b0;
      stb.ldByte   = 1'b0;
      stb.bufDone  = 1'b0;
      stb.ownIdle  = 1'b0;
      stb.halt     = 1'b1;
      stNext       = S_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= S_IDLE;
    else       st <= stNext;
  end

  // R5: write-back only once the whole buffer has gone out
  a_r5_wb_after_full: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> lenDone);

  // R3: never push beyond the buffer length
  a_r3_push_within_len: assert property (@(posedge clk) disable iff (!rstN)
    fifoPush |-> !lenDone);

  // R4: a push is only issued while the FIFO has room
  a_r4_push_needs_space: assert property (@(posedge clk) disable iff (!rstN)
    fifoPush |-> fifoSpace);

endmodule

// File: rtl/ring_tx_dma_dp.sv
module ring_tx_dma_dp
  import ring_tx_dma_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int RING_LEN = 16,
  parameter int CNT_W    = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         stb,
  input  addrSel_t          addrSel,
  input  logic              epUnderrun,
  input  logic              epNak,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [15:0]       regWdata,
  output logic [15:0]       regRdata,
  input  logic [15:0]       memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [15:0]       memWdata,
  output logic [7:0]        fifoData,
  output logic              run,
  output logic              lenDone,
  output logic              irq
);

  localparam int IDX_W = $clog2(RING_LEN);
  localparam int HI_W  = ADDR_W - 16;

  logic              tcEn, statTtc, statUnder, statNak;
  logic [11:0]       ringLo;
  logic [HI_W-1:0]   ringHi;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] txAddr, ringBase, descAddr;
  logic [14:0]       cfgQ;
  logic [CNT_W-1:0]  bufLen, sentCnt;
  logic [7:0]        byteQ;
  logic [2:0]        wordOff;
  logic              wrCtrl, wrStat;

  assign wrCtrl = regWe && (regAddr == REG_CTRL);
  assign wrStat = regWe && (regAddr == REG_STAT);

  assign ringBase = {ringHi, ringLo, 4'b0000};

  always_comb begin
    unique case (addrSel)
      SEL_ALO: wordOff = 3'd0;
      SEL_CNT: wordOff = 3'd4;
      default: wordOff = 3'd2;
    endcase
  end

  assign descAddr = ringBase + ADDR_W'({idx, 3'b000}) + ADDR_W'(wordOff);
  assign memAddr  = (addrSel == SEL_DATA) ? txAddr : descAddr;
  assign memWdata = {1'b0, cfgQ};
  assign fifoData = byteQ;
  assign lenDone  = (sentCnt == bufLen);
  assign irq      = statTtc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      run       <= 1'b0;
      tcEn      <= 1'b0;
      statTtc   <= 1'b0;
      statUnder <= 1'b0;
      statNak   <= 1'b0;
      ringLo    <= '0;
      ringHi    <= '0;
      idx       <= '0;
      txAddr    <= '0;
      cfgQ      <= '0;
      bufLen    <= '0;
      sentCnt   <= '0;
      byteQ     <= '0;
    end else begin
      // software register writes
      if (wrCtrl) begin
        tcEn <= regWdata[1];
        if (regWdata[0]) run <= 1'b1;
      end
      if (wrStat) begin
        if (regWdata[0]) statTtc   <= 1'b0;
        if (regWdata[1]) statUnder <= 1'b0;
        if (regWdata[2]) statNak   <= 1'b0;
      end
      if (regWe && regAddr == REG_RINGLO) ringLo <= regWdata[15:4];
      if (regWe && regAddr == REG_RINGHI) ringHi <= regWdata[HI_W-1:0];
      if (regWe && regAddr == REG_INDEX)  idx    <= regWdata[IDX_W-1:0];

      // channel events; setting a status bit wins over clearing it
      if (stb.ldCfg)    cfgQ   <= memRdata[14:0];
      if (stb.ldAddrLo) txAddr <= {cfgQ[HI_W-1:0], memRdata};
      if (stb.ldLen) begin
        bufLen  <= CNT_W'(~memRdata[CNT_W-1:0]) + CNT_W'(1);
        sentCnt <= '0;
      end
      if (stb.ldByte)  byteQ <= txAddr[0] ? memRdata[15:8] : memRdata[7:0];
      if (stb.advByte) begin
        txAddr  <= txAddr + ADDR_W'(1);
        sentCnt <= sentCnt + CNT_W'(1);
      end
      if (stb.bufDone) begin
        idx <= idx + IDX_W'(1);
        if (tcEn) statTtc <= 1'b1;
      end
      if (stb.ownIdle) run <= 1'b0;
      if (stb.halt) begin
        run <= 1'b0;
        if (epUnderrun) statUnder <= 1'b1;
        if (epNak)      statNak   <= 1'b1;
      end
    end
  end

  always_comb begin
    unique case (regAddr)
      REG_CTRL:   regRdata = {14'b0, tcEn, run};
      REG_STAT:   regRdata = {13'b0, statNak, statUnder, statTtc};
      REG_RINGLO: regRdata = {ringLo, 4'b0000};
      REG_RINGHI: regRdata = 16'(ringHi);
      REG_INDEX:  regRdata = 16'(idx);
      REG_TXLO:   regRdata = txAddr[15:0];
      REG_TXHI:   regRdata = 16'(txAddr[ADDR_W-1:16]);
      default:    regRdata = 16'(sentCnt);
    endcase
  end

  // R8: while stopped, the live transmit address is frozen
  a_r8_addr_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> $stable(txAddr));

  // R7: the completion flag only rises when the interrupt enable was set
  a_r7_ttc_needs_en: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statTtc) |-> $past(tcEn));

  // R3: the sent count never passes the buffer length
  a_r3_sent_le_len: assert property (@(posedge clk) disable iff (!rstN)
    sentCnt <= bufLen);

endmodule

// File: rtl/ring_tx_dma.sv
module ring_tx_dma
  import ring_tx_dma_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int RING_LEN = 16,
  parameter int CNT_W    = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [15:0]       regWdata,
  output logic [15:0]       regRdata,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [15:0]       memWdata,
  input  logic              memAck,
  input  logic [15:0]       memRdata,
  output logic              fifoPush,
  output logic [7:0]        fifoData,
  input  logic              fifoSpace,
  input  logic              epUnderrun,
  input  logic              epNak,
  output logic              irq
);

  txStrobe_t stb;
  addrSel_t  addrSel;
  logic      run, lenDone;

  ring_tx_dma_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .run       (run),
    .errIn     (epUnderrun | epNak),
    .lenDone   (lenDone),
    .ownBit    (memRdata[15]),
    .memAck    (memAck),
    .fifoSpace (fifoSpace),
    .memReq    (memReq),
    .memWe     (memWe),
    .addrSel   (addrSel),
    .fifoPush  (fifoPush),
    .stb       (stb)
  );

  ring_tx_dma_dp #(
    .ADDR_W   (ADDR_W),
    .RING_LEN (RING_LEN),
    .CNT_W    (CNT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .addrSel    (addrSel),
    .epUnderrun (epUnderrun),
    .epNak      (epNak),
    .regWe      (regWe),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .regRdata   (regRdata),
    .memRdata   (memRdata),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .fifoData   (fifoData),
    .run        (run),
    .lenDone    (lenDone),
    .irq        (irq)
  );

endmodule

// File: tb/ring_tx_dma_bench.sv
`timescale 1ns/1ps
module ring_tx_dma_bench;

  localparam int AW = 20;
  localparam logic [15:0] RING = 16'h0100;
  localparam logic [15:0] CFGW = 16'h2A00;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [15:0] regWdata = 16'h0;
  logic [15:0] regRdata;
  logic        memReq, memWe, memAck;
  logic [AW-1:0] memAddr;
  logic [15:0] memWdata, memRdata;
  logic        fifoPush, fifoSpace;
  logic [7:0]  fifoData;
  logic        epUnderrun = 1'b0;
  logic        epNak = 1'b0;
  logic        irq;

  always #10 clk = ~clk;

  ring_tx_dma u_ring_tx_dma (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata), .fifoPush(fifoPush),
    .fifoData(fifoData), .fifoSpace(fifoSpace), .epUnderrun(epUnderrun),
    .epNak(epNak), .irq(irq)
  );

  // memory model: read-only words written by the bench, write-backs recorded
  logic [15:0] mem [4096];
  assign memAck   = memReq;
  assign memRdata = mem[memAddr[12:1]];

  int          wbCnt = 0;
  logic [AW-1:0] wbAddr = '0;
  logic [15:0] wbData = '0;
  always @(posedge clk)
    if (memReq && memWe && memAck) begin
      wbCnt  <= wbCnt + 1;
      wbAddr <= memAddr;
      wbData <= memWdata;
    end

  // FIFO model
  logic [7:0] cap [1024];
  int pushCnt = 0;
  int spaceViol = 0;
  always @(posedge clk)
    if (fifoPush) begin
      cap[pushCnt % 1024] <= fifoData;
      pushCnt <= pushCnt + 1;
      if (!fifoSpace) spaceViol <= spaceViol + 1;
    end

  logic [7:0] spacePat = 8'hFF;
  logic [2:0] patIdx = 3'd0;
  initial fifoSpace = 1'b1;
  always @(negedge clk) begin
    patIdx    <= patIdx + 3'd1;
    fifoSpace <= spacePat[patIdx];
  end

  int nChk = 0;
  int nFail = 0;

  function automatic logic [7:0] byteAt(input int a);
    return 8'(a * 13 + (a >> 7) + 1);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic regWr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic setDesc(input int idx, input int addr, input int len, input bit own);
    int w;
    w = (int'(RING) + idx * 8) / 2;
    mem[w]     = 16'(addr);
    mem[w + 1] = own ? (CFGW | 16'h8000) : CFGW;
    mem[w + 2] = (len == 0) ? 16'h8000 : {1'b1, 15'(15'd0 - 15'(len))};
    mem[w + 3] = 16'h0;
  endtask

  task automatic waitIdle();
    logic [15:0] v;
    for (int n = 0; n < 5000; n++) begin
      regRd(3'd0, v);
      if (!v[0]) break;
    end
  endtask

  task automatic checkBytes(input string tag, input int p0, input int addr, input int len);
    int bad;
    bad = 0;
    for (int i = 0; i < len; i++)
      if (cap[(p0 + i) % 1024] !== byteAt(addr + i)) bad++;
    chk(tag, 32'(bad), 32'd0);
  endtask

  // vector: {startIdx[4], bufAddr[16], len[8], spacePat[8], tcEn[1]}
  localparam int NV = 4;
  localparam logic [36:0] VEC [NV] = '{
    {4'd0,  16'h0401, 8'd5,  8'hFF,        1'b1},
    {4'd3,  16'h0600, 8'd40, 8'b1001_0110, 1'b0},
    {4'd15, 16'h0800, 8'd1,  8'h01,        1'b1},
    {4'd7,  16'h0900, 8'd0,  8'hFF,        1'b1}
  };

  task automatic runAll();
    logic [15:0] v;
    int p0, w0, e, pre;
    bit pv;

    for (int w = 0; w < 4096; w++) mem[w] = {byteAt(2 * w + 1), byteAt(2 * w)};

    // R1: reset state
    #5;
    chk("R1 memReq", 32'(memReq), 0);
    chk("R1 fifoPush", 32'(fifoPush), 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    regRd(3'd0, v); chk("R1 ctrl", 32'(v), 0);
    regRd(3'd1, v); chk("R1 status", 32'(v), 0);
    regRd(3'd4, v); chk("R1 index", 32'(v), 0);
    chk("R1 irq", 32'(irq), 0);

    // R6: ring base alignment
    regWr(3'd2, RING | 16'h0005);
    regWr(3'd3, 16'h0000);
    regRd(3'd2, v); chk("R6 base aligned", 32'(v), 32'(RING));

    // table-driven buffer transfers
    for (int k = 0; k < NV; k++) begin
      int idx, addr, len, nxt;
      bit ten;
      idx = int'(VEC[k][36:33]); addr = int'(VEC[k][32:17]);
      len = int'(VEC[k][16:9]);  ten = VEC[k][0];
      nxt = (idx + 1) % 16;
      spacePat = VEC[k][8:1];
      setDesc(idx, addr, len, 1'b1);
      setDesc(nxt, 0, 0, 1'b0);
      regWr(3'd1, 16'h0007);
      regWr(3'd0, {14'b0, ten, 1'b0});
      regWr(3'd4, 16'(idx));
      p0 = pushCnt; w0 = wbCnt;
      regWr(3'd0, {14'b0, ten, 1'b1});
      waitIdle();
      chk($sformatf("R3 count v%0d", k), 32'(pushCnt - p0), 32'(len));
      checkBytes($sformatf("R3 data v%0d", k), p0, addr, len);
      regRd(3'd7, v); chk($sformatf("R3 sent v%0d", k), 32'(v), 32'(len));
      regRd(3'd5, v); chk($sformatf("R3 txaddr v%0d", k), 32'(v), 32'(16'(addr + len)));
      chk($sformatf("R5 one writeback v%0d", k), 32'(wbCnt - w0), 1);
      chk($sformatf("R5 own cleared v%0d", k), 32'(wbData), 32'(CFGW));
      chk($sformatf("R5 wb slot v%0d", k), 32'(wbAddr), 32'(int'(RING) + idx * 8 + 2));
      regRd(3'd4, v); chk($sformatf("R6 index advance v%0d", k), 32'(v), 32'(nxt));
      regRd(3'd1, v); chk($sformatf("R7 status v%0d", k), 32'(v), 32'(ten));
      chk($sformatf("R7 irq v%0d", k), 32'(irq), 32'(ten));
      regRd(3'd0, v); chk($sformatf("R2 idle at unowned v%0d", k), 32'(v[0]), 0);
    end

    // R7: write-1-to-clear of completion bit
    regWr(3'd1, 16'h0001);
    regRd(3'd1, v); chk("R7 w1c", 32'(v), 0);
    chk("R7 irq cleared", 32'(irq), 0);

    // R2: unowned descriptor
    spacePat = 8'hFF;
    setDesc(5, 16'h0A00, 4, 1'b0);
    regWr(3'd4, 16'd5);
    p0 = pushCnt; w0 = wbCnt;
    regWr(3'd0, 16'h0001);
    waitIdle();
    regRd(3'd4, v); chk("R2 index kept", 32'(v), 5);
    regRd(3'd1, v); chk("R2 no status", 32'(v), 0);
    chk("R2 no push", 32'(pushCnt - p0), 0);
    chk("R2 no write", 32'(wbCnt - w0), 0);

    // R8: underrun mid-buffer
    setDesc(8, 16'h0C00, 20, 1'b1);
    setDesc(9, 0, 0, 1'b0);
    regWr(3'd4, 16'd8);
    p0 = pushCnt; w0 = wbCnt;
    regWr(3'd0, 16'h0003);
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      if (pushCnt - p0 >= 7) break;
    end
    #1 pv = fifoPush; pre = pushCnt - p0;
    epUnderrun = 1'b1;
    @(negedge clk);
    epUnderrun = 1'b0;
    e = pre + int'(pv);
    repeat (20) @(negedge clk);
    chk("R8 pushes stop", 32'(pushCnt - p0), 32'(e));
    regRd(3'd0, v); chk("R8 stopped", 32'(v[0]), 0);
    regRd(3'd1, v); chk("R8 status", 32'(v), 32'h2);
    regRd(3'd5, v); chk("R8 txaddr kept", 32'(v), 32'(16'h0C00 + e));
    regRd(3'd7, v); chk("R8 sent kept", 32'(v), 32'(e));
    regRd(3'd4, v); chk("R8 index kept", 32'(v), 8);
    chk("R8 no writeback", 32'(wbCnt - w0), 0);
    checkBytes("R8 partial data", p0, 16'h0C00, e);

    // R10: back up to buffer start and resend
    regWr(3'd1, 16'h0002);
    regRd(3'd1, v); chk("R7 w1c error bit", 32'(v), 0);
    setDesc(8, 16'h0C00, 20, 1'b1);
    regWr(3'd4, 16'd8);
    p0 = pushCnt; w0 = wbCnt;
    regWr(3'd0, 16'h0003);
    waitIdle();
    chk("R10 resend count", 32'(pushCnt - p0), 20);
    checkBytes("R10 resend data", p0, 16'h0C00, 20);
    chk("R10 writeback", 32'(wbCnt - w0), 1);
    regRd(3'd4, v); chk("R10 index", 32'(v), 9);

    // R9: NAK stop
    regWr(3'd1, 16'h0007);
    setDesc(10, 16'h0D00, 16, 1'b1);
    setDesc(11, 0, 0, 1'b0);
    regWr(3'd4, 16'd10);
    p0 = pushCnt; w0 = wbCnt;
    regWr(3'd0, 16'h0001);
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      if (pushCnt - p0 >= 3) break;
    end
    #1 pv = fifoPush; pre = pushCnt - p0;
    epNak = 1'b1;
    @(negedge clk);
    epNak = 1'b0;
    e = pre + int'(pv);
    repeat (20) @(negedge clk);
    chk("R9 pushes stop", 32'(pushCnt - p0), 32'(e));
    regRd(3'd1, v); chk("R9 status", 32'(v), 32'h4);
    regRd(3'd5, v); chk("R9 txaddr kept", 32'(v), 32'(16'h0D00 + e));
    chk("R9 no writeback", 32'(wbCnt - w0), 0);

    // R11: underrun in the cycle of the last byte push
    regWr(3'd1, 16'h0007);
    setDesc(12, 16'h0E00, 6, 1'b1);
    setDesc(13, 0, 0, 1'b0);
    regWr(3'd4, 16'd12);
    p0 = pushCnt; w0 = wbCnt;
    regWr(3'd0, 16'h0003);
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      #1;
      if (fifoPush && (pushCnt - p0 == 5)) break;
    end
    epUnderrun = 1'b1;
    @(negedge clk);
    epUnderrun = 1'b0;
    repeat (20) @(negedge clk);
    chk("R11 last push counted", 32'(pushCnt - p0), 6);
    regRd(3'd7, v); chk("R11 sent full", 32'(v), 6);
    chk("R11 no writeback", 32'(wbCnt - w0), 0);
    regRd(3'd1, v); chk("R11 status underrun only", 32'(v), 32'h2);
    chk("R11 no irq", 32'(irq), 0);
    regRd(3'd4, v); chk("R11 index kept", 32'(v), 12);

    chk("R4 no push without space", 32'(spaceViol), 0);
  endtask

  initial begin
    bit wdFired;
    wdFired = 1'b0;
    fork
      runAll();
      begin
        repeat (150000) @(posedge clk);
        wdFired = 1'b1;
      end
    join_any
    if (wdFired) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule